// File: doc/BRIEF.md
# Set/Clear-Mask Interrupt Control Unit

This block gathers 64 interrupt request lines and presents one winner to the CPU. The winner is the highest-priority source that is both requesting and unmasked. Each source has a 3-bit priority level, and a 64-bit mask gates whether it can request.

Software changes the mask one bit at a time with single-byte writes. It writes a source number to the set-mask register to block that source, or to the clear-mask register to enable it. Neither operation needs a read-modify-write. Writing 0xFF to either register blocks or enables every source at once. Each source's level is held in its own byte register, located at the source number within the register space.

Request inputs, the mask and the levels are all registered. The output is decoded from those registers, so it reflects any change one clock later.

Top module: `scm_intc`

## Requirements
- R1: After reset every mask bit is set and every level is 0, so `irq_valid` stays 0 whatever the request lines do.
- R2: A write of a value N (0..63) to address 0x40 (set-mask) sets mask bit N, which blocks source N.
- R3: A write of a value N (0..63) to address 0x41 (clear-mask) clears mask bit N, which enables source N.
- R4: A write of 0xFF to address 0x40 sets all 64 mask bits.
- R5: A write of 0xFF to address 0x41 clears all 64 mask bits.
- R6: A write of a value from 64 to 0xFE to address 0x40 or 0x41 leaves the mask unchanged. In particular, the low six bits of such a value are not used as a source number.
- R7: A write to address N (0..63) stores data bits [2:0] as the level of source N, and data bits [7:3] are discarded.
- R8: A source at level 0 never wins, even when it is requesting and unmasked.
- R9: The output names the requesting, unmasked source with the highest level (7 is the highest). When two or more sources share that level, the source with the lowest index wins.
- R10: The output changes exactly one clock edge after a change on `irq_req` or a completed register write, and not before.
- R11: When `irq_valid` is 0, `irq_src` and `irq_lvl` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 7 | Write address: 0x00-0x3F levels, 0x40 set-mask, 0x41 clear-mask |
| wr_data | input | 8 | Write data byte |
| irq_req | input | 64 | Request lines, one per source |
| irq_valid | output | 1 | A source is being presented |
| irq_src | output | 6 | Index of the presented source |
| irq_lvl | output | 3 | Level of the presented source |

## Verification
The assertions check the following on every cycle:
- The effect of every set-mask and clear-mask write on the mask, including the broadcast value 0xFF and the ignored range of values.
- That a presented source is requesting, unmasked and at a nonzero level.
- That the index and level read zero whenever `irq_valid` is 0.

Other properties can only be shown by the bench's scenarios:
- That the winner is the correct one among several contenders, including the tie rule.
- That the upper data bits of a level write are discarded.
- The exact one-cycle latency as seen at the ports.

// File: rtl/scm_intc.sv
module scm_intc #(
  parameter int NSRC = 64,
  parameter int LVLW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [6:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [NSRC-1:0]           irq_req,
  output logic                      irq_valid,
  output logic [$clog2(NSRC)-1:0]   irq_src,
  output logic [LVLW-1:0]           irq_lvl
);
  localparam int IDXW = $clog2(NSRC);
  localparam logic [6:0] ADDR_SET = 7'h40;
  localparam logic [6:0] ADDR_CLR = 7'h41;
  localparam logic [7:0] ALL      = 8'hFF;

  logic [NSRC-1:0] req_q, mask_q;
  logic [LVLW-1:0] lvl_q [NSRC];

  wire idx_ok  = wr_data < 8'(NSRC);
  wire set_wr  = wr_en && wr_addr == ADDR_SET;
  wire clr_wr  = wr_en && wr_addr == ADDR_CLR;
  wire lvl_wr  = wr_en && wr_addr < 7'(NSRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '1;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      req_q <= irq_req;
      if (set_wr && wr_data == ALL)      mask_q <= '1;
      else if (set_wr && idx_ok)         mask_q[wr_data[IDXW-1:0]] <= 1'b1;
      if (clr_wr && wr_data == ALL)      mask_q <= '0;
      else if (clr_wr && idx_ok)         mask_q[wr_data[IDXW-1:0]] <= 1'b0;
      if (lvl_wr) lvl_q[wr_addr[IDXW-1:0]] <= wr_data[LVLW-1:0];
    end
  end

  always_comb begin
    irq_valid = 1'b0;
    irq_src   = '0;
    irq_lvl   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_q[i] && !mask_q[i] && lvl_q[i] != '0 && lvl_q[i] >= irq_lvl) begin
        irq_valid = 1'b1;
        irq_src   = IDXW'(i);
        irq_lvl   = lvl_q[i];
      end
    end
  end

  AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr && wr_data == ALL |=> &mask_q);  // R4
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && wr_data == ALL |=> mask_q == '0);  // R5
  AST_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr && idx_ok |=> mask_q[$past(wr_data[IDXW-1:0])]);  // R2
  AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && idx_ok |=> !mask_q[$past(wr_data[IDXW-1:0])]);  // R3
  AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr || clr_wr) && !idx_ok && wr_data != ALL |=> $stable(mask_q));  // R6
  AST_WIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_lvl != '0 && req_q[irq_src] && !mask_q[irq_src]);  // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_src == '0 && irq_lvl == '0);  // R11
endmodule

// File: tb/scm_intc_bench.sv
module scm_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [63:0] irq_req = '0;
  logic        irq_valid;
  logic [5:0]  irq_src;
  logic [2:0]  irq_lvl;

  int checks = 0;
  int errors = 0;

  scm_intc u_scm_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_req(irq_req), .irq_valid(irq_valid), .irq_src(irq_src), .irq_lvl(irq_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Each entry: {requests, valid, src, lvl}. Levels configured as source index mod 8.
  localparam logic [73:0] VEC [NV] = '{
    {64'h0,                   1'b0, 6'd0,  3'd0},  // R11 nothing requests
    {64'h1,                   1'b0, 6'd0,  3'd0},  // R8 level 0 source
    {64'h8,                   1'b1, 6'd3,  3'd3},  // R9 single source
    {64'h28,                  1'b1, 6'd5,  3'd5},  // R9 higher level wins
    {64'h8080,                1'b1, 6'd7,  3'd7},  // R9 tie, lowest index
    {64'hC000_0000_0000_0000, 1'b1, 6'd63, 3'd7},  // R9 top sources
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd7,  3'd7},  // R9 all requesting
    {64'h1_0100,              1'b0, 6'd0,  3'd0},  // R8 only level 0 sources
    {64'h2_0200,              1'b1, 6'd9,  3'd1},  // R9 tie at level 1
    {64'h0000_0040_0000_0006, 1'b1, 6'd38, 3'd6}   // R9 far index beats low
  };

  task automatic check(input string req, input logic v, input logic [5:0] s, input logic [2:0] l);
    checks++;
    if (irq_valid !== v || irq_src !== s || irq_lvl !== l) begin
      errors++;
      $display("FAIL %s: got v=%0b src=%0d lvl=%0d, expected v=%0b src=%0d lvl=%0d",
               req, irq_valid, irq_src, irq_lvl, v, s, l);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [63:0] r);
    @(negedge clk);
    irq_req = r;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive('1);
    check("R1 reset masks all", 1'b0, 6'd0, 3'd0);
    wr(7'h41, 8'hFF);
    drive('1);
    check("R1 reset levels zero", 1'b0, 6'd0, 3'd0);

    for (int i = 0; i < 64; i++) wr(7'(i), 8'(i % 8));
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][73:10]);
      check("R9 vector", VEC[k][9], VEC[k][8:3], VEC[k][2:0]);
    end

    drive('1);
    wr(7'h40, 8'd7);
    check("R2 mask source 7", 1'b1, 6'd15, 3'd7);
    wr(7'h40, 8'h47);
    check("R6 set 0x47 ignored", 1'b1, 6'd15, 3'd7);
    wr(7'h40, 8'hFF);
    check("R4 set all", 1'b0, 6'd0, 3'd0);
    wr(7'h41, 8'd23);
    check("R3 unmask source 23", 1'b1, 6'd23, 3'd7);
    wr(7'h41, 8'h4E);
    check("R6 clear 0x4E ignored", 1'b1, 6'd23, 3'd7);
    wr(7'h41, 8'hFE);
    check("R6 clear 0xFE ignored", 1'b1, 6'd23, 3'd7);
    wr(7'h41, 8'hFF);
    check("R5 clear all", 1'b1, 6'd7, 3'd7);

    wr(7'd5, 8'hF9);
    drive(64'h30);
    check("R7 upper bits dropped", 1'b1, 6'd4, 3'd4);

    @(negedge clk);
    irq_req = 64'h20;
    #1 check("R10 no early change", 1'b1, 6'd4, 3'd4);
    @(negedge clk);
    check("R10 one clock later", 1'b1, 6'd5, 3'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule